// File: doc/BRIEF.md
# Masked device interrupt router

The block sits between a set of interrupt-raising devices and the network that delivers vectored interrupts to processors. Every device owns one slot. A slot holds a target processor number, a vector number, a mask flag and a pending flag. Software programs and inspects the slots through a small memory-mapped read/write port. Each access gets a registered response one cycle later.

A device raises a request by driving its `dev_irq` bit high for a cycle. If its slot is masked, the request is dropped with no trace. If the slot is open, the block closes it (mask set), records the event (pending set) and queues a delivery. A lowest-index-first picker then emits one delivery per clock on the post bundle, carrying the slot's programmed processor and vector. Because the slot masks itself on capture, a device gets one delivery until software reopens it. Pending is cleared separately, by writing one to a dedicated bit.

Address map: routing slot n sits at byte offset 0x000 + 8·n and control slot n at 0x100 + 8·n. Any other offset is unmapped. The number of devices is a parameter, up to 32.

Top module: `irq_route_bank`

## Requirements
- R1: While reset is held and after it is released, every slot is masked and not pending, with processor 0 and vector 0. No post and no response is emitted until a request arrives.
- R2: A routing register (offset 0x000 + 8·n) stores the processor from write bits 12:8 and the vector from write bits 5:0. It reads back in the same positions, with every other bit zero.
- R3: A control register (offset 0x100 + 8·n) reads the mask in bit 2 and pending in bit 0, with all other bits zero. The two bits are reported independently, so pending shows even while the slot is unmasked.
- R4: A control write loads the mask from bit 2. A one in bit 1 clears pending, and a zero in bit 1 leaves pending as it was.
- R5: A `dev_irq` pulse on a masked slot changes nothing: pending stays as it was and no post results.
- R6: A `dev_irq` pulse on an unmasked slot sets that slot's mask and pending on the sampling edge. On the following edge, `post_valid` rises for exactly one cycle with the slot's processor and vector.
- R7: When several slots capture in the same cycle, posts go out one per cycle in increasing device order. Requests not yet posted stay queued.
- R8: An access whose offset is misaligned, lies outside both register banks, or names a device index at or above the device count returns `rsp_err`=1 with read data 0. A write to such an offset changes no state.
- R9: Each request produces exactly one response with `rsp_valid` high in the next cycle. Read data reflects the state before any same-cycle update, and write responses carry data 0.
- R10: When a capture and a control write to the same slot happen in one cycle, the capture wins. The slot ends masked and pending, and the post still goes out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_err | output | 1 | Access hit an unmapped offset |
| rsp_rdata | output | 32 | Read data |
| dev_irq | input | NUM_DEV | Per-device interrupt pulses |
| post_valid | output | 1 | Delivery strobe |
| post_cpu | output | 5 | Target processor of the delivery |
| post_vec | output | 6 | Vector of the delivery |

## Verification
Device capture and software writes to the same slot's control register can land on the same clock edge. The bench opens a slot and then, on one falling edge, raises the slot's `dev_irq` together with a control write that requests unmask and pending clear. It then expects the post two edges later and a control readback of mask and pending both set. Coincident captures on two slots are provoked in a single cycle, and the bench judges the back-to-back posts by their order and their processor and vector values.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    // Port and field geometry. Positions are fixed by the register layout.
    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam int CPU_W    = 5;
    localparam int VEC_W    = 6;
    localparam int CPU_LSB  = 8;
    localparam int VEC_LSB  = 0;
    localparam int MASK_BIT = 2;
    localparam int CLR_BIT  = 1;
    localparam int PEND_BIT = 0;

    // Offset decomposition: [11:8] bank, [7:3] slot index, [2:0] must be zero
    localparam int IDX_LSB  = 3;
    localparam int IDX_W    = 5;
    localparam int BANK_LSB = 8;
    localparam int BANK_W   = ADDR_W - BANK_LSB;
    localparam logic [BANK_W-1:0] BANK_ROUTE = 4'h0;
    localparam logic [BANK_W-1:0] BANK_CTRL  = 4'h1;

    typedef enum logic [1:0] {
        RGN_NONE  = 2'd0,
        RGN_ROUTE = 2'd1,
        RGN_CTRL  = 2'd2
    } region_e;

    typedef struct packed {
        logic [CPU_W-1:0] cpu;
        logic [VEC_W-1:0] vec;
    } route_t;

    function automatic logic [DATA_W-1:0] pack_route(input route_t r);
        logic [DATA_W-1:0] d;
        d = '0;
        d[CPU_LSB +: CPU_W] = r.cpu;
        d[VEC_LSB +: VEC_W] = r.vec;
        return d;
    endfunction

    function automatic route_t unpack_route(input logic [DATA_W-1:0] d);
        route_t r;
        r.cpu = d[CPU_LSB +: CPU_W];
        r.vec = d[VEC_LSB +: VEC_W];
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input logic m, input logic p);
        logic [DATA_W-1:0] d;
        d = '0;
        d[MASK_BIT] = m;
        d[PEND_BIT] = p;
        return d;
    endfunction

endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
    import irq_route_pkg::*;
#(
    parameter int NUM_DEV = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           rgn,
    output logic [IDX_W-1:0]  idx
);
    logic [BANK_W-1:0] bank;
    logic              aligned;
    logic              in_range;

    always_comb begin
        bank     = addr[BANK_LSB +: BANK_W];
        idx      = addr[IDX_LSB +: IDX_W];
        aligned  = (addr[IDX_LSB-1:0] == '0);
        in_range = (int'(idx) < NUM_DEV);
        rgn      = RGN_NONE;
        if (aligned && in_range) begin
            if (bank == BANK_ROUTE)
                rgn = RGN_ROUTE;
            else if (bank == BANK_CTRL)
                rgn = RGN_CTRL;
        end
    end
endmodule

// File: rtl/irq_route_slots.sv
module irq_route_slots
    import irq_route_pkg::*;
#(
    parameter int NUM_DEV = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  region_e            wr_rgn,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_DEV-1:0] dev_irq,
    input  logic [NUM_DEV-1:0] grant_oh,
    output route_t             route_q [NUM_DEV],
    output logic [NUM_DEV-1:0] mask_q,
    output logic [NUM_DEV-1:0] pend_q,
    output logic [NUM_DEV-1:0] req_q
);
    for (genvar g = 0; g < NUM_DEV; g++) begin : g_slot
        logic   hit;
        logic   cap;
        route_t rt_r;
        logic   m_r;
        logic   p_r;
        logic   q_r;

        assign hit = wr_en && (wr_idx == IDX_W'(g));
        assign cap = dev_irq[g] && !m_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                rt_r <= '0;
                m_r  <= 1'b1;
                p_r  <= 1'b0;
                q_r  <= 1'b0;
            end else begin
                if (hit && wr_rgn == RGN_ROUTE)
                    rt_r <= unpack_route(wdata);
                // a capture outranks a same-cycle control write
                if (cap) begin
                    m_r <= 1'b1;
                    p_r <= 1'b1;
                end else if (hit && wr_rgn == RGN_CTRL) begin
                    m_r <= wdata[MASK_BIT];
                    if (wdata[CLR_BIT])
                        p_r <= 1'b0;
                end
                q_r <= (q_r && !grant_oh[g]) || cap;
            end
        end

        assign route_q[g] = rt_r;
        assign mask_q[g]  = m_r;
        assign pend_q[g]  = p_r;
        assign req_q[g]   = q_r;
    end
endmodule

// File: rtl/irq_route_pick.sv
module irq_route_pick #(
    parameter int NUM_DEV = 8
) (
    input  logic [NUM_DEV-1:0] req,
    output logic [NUM_DEV-1:0] grant_oh,
    output logic               any
);
    logic [NUM_DEV:0] seen;

    assign seen[0] = 1'b0;
    for (genvar g = 0; g < NUM_DEV; g++) begin : g_chain
        assign grant_oh[g] = req[g] && !seen[g];
        assign seen[g+1]   = seen[g] || req[g];
    end
    assign any = seen[NUM_DEV];
endmodule

// File: rtl/irq_route_bank.sv
module irq_route_bank
    import irq_route_pkg::*;
#(
    parameter int NUM_DEV = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [11:0]        req_addr,
    input  logic [31:0]        req_wdata,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic [31:0]        rsp_rdata,
    input  logic [NUM_DEV-1:0] dev_irq,
    output logic               post_valid,
    output logic [4:0]         post_cpu,
    output logic [5:0]         post_vec
);
    region_e            rgn;
    logic [IDX_W-1:0]   idx;
    route_t             slot_route [NUM_DEV];
    logic [NUM_DEV-1:0] slot_mask;
    logic [NUM_DEV-1:0] slot_pend;
    logic [NUM_DEV-1:0] slot_req;
    logic [NUM_DEV-1:0] grant_oh;
    logic               grant_any;
    logic [DATA_W-1:0]  rd_word;
    route_t             grant_route;

    irq_route_decode #(.NUM_DEV(NUM_DEV)) u_dec (
        .addr (req_addr),
        .rgn  (rgn),
        .idx  (idx)
    );

    irq_route_slots #(.NUM_DEV(NUM_DEV)) u_slots (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (req_valid && req_write),
        .wr_rgn   (rgn),
        .wr_idx   (idx),
        .wdata    (req_wdata),
        .dev_irq  (dev_irq),
        .grant_oh (grant_oh),
        .route_q  (slot_route),
        .mask_q   (slot_mask),
        .pend_q   (slot_pend),
        .req_q    (slot_req)
    );

    irq_route_pick #(.NUM_DEV(NUM_DEV)) u_pick (
        .req      (slot_req),
        .grant_oh (grant_oh),
        .any      (grant_any)
    );

    // read mux and granted route, both selected by comparison loops
    always_comb begin
        rd_word     = '0;
        grant_route = '0;
        for (int i = 0; i < NUM_DEV; i++) begin
            if (idx == IDX_W'(i)) begin
                if (rgn == RGN_ROUTE)
                    rd_word = pack_route(slot_route[i]);
                else if (rgn == RGN_CTRL)
                    rd_word = pack_ctrl(slot_mask[i], slot_pend[i]);
            end
            if (grant_oh[i])
                grant_route = grant_route | slot_route[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_err    <= 1'b0;
            rsp_rdata  <= '0;
            post_valid <= 1'b0;
            post_cpu   <= '0;
            post_vec   <= '0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_err    <= req_valid && (rgn == RGN_NONE);
            rsp_rdata  <= (req_valid && !req_write) ? rd_word : '0;
            post_valid <= grant_any;
            post_cpu   <= grant_any ? grant_route.cpu : '0;
            post_vec   <= grant_any ? grant_route.vec : '0;
        end
    end
endmodule

// File: rtl/irq_route_bank_chk.sv
module irq_route_bank_chk
    import irq_route_pkg::*;
#(
    parameter int NUM_DEV = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_write,
    input logic [11:0]        req_addr,
    input logic [31:0]        req_wdata,
    input logic               rsp_valid,
    input logic               rsp_err,
    input logic [31:0]        rsp_rdata,
    input logic [NUM_DEV-1:0] dev_irq,
    input logic               post_valid,
    input logic [NUM_DEV-1:0] slot_mask,
    input logic [NUM_DEV-1:0] slot_pend,
    input logic [NUM_DEV-1:0] slot_req
);
    // R1: outputs quiet in the cycle after reset is sampled
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!post_valid && !rsp_valid));

    // R9: one response, exactly one cycle later
    a_r9_rsp_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    a_r9_rsp_idle: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R8: error responses carry no data
    a_r8_err_nodata: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_valid && rsp_rdata == '0));

    // R7: every post comes from a queued request
    a_r7_post_queued: assert property (@(posedge clk) disable iff (rst)
        post_valid |-> $past(|slot_req));

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_chk
        localparam logic [11:0] CTRL_OFS = 12'(256 + 8 * g);

        // R6: capture closes the slot and records it
        a_r6_capture_sets: assert property (@(posedge clk) disable iff (rst)
            (dev_irq[g] && !slot_mask[g]) |=> (slot_mask[g] && slot_pend[g]));

        // R5: a masked slot never gains pending without software
        a_r5_masked_ignored: assert property (@(posedge clk) disable iff (rst)
            (slot_mask[g] && !slot_pend[g] && !(req_valid && req_write))
            |=> !slot_pend[g]);

        // R4: write-one to the clear bit drops pending
        a_r4_clear_pend: assert property (@(posedge clk) disable iff (rst)
            (req_valid && req_write && req_addr == CTRL_OFS
             && req_wdata[CLR_BIT] && !(dev_irq[g] && !slot_mask[g]))
            |=> !slot_pend[g]);
    end
endmodule

bind irq_route_bank irq_route_bank_chk #(.NUM_DEV(NUM_DEV)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .rsp_rdata  (rsp_rdata),
    .dev_irq    (dev_irq),
    .post_valid (post_valid),
    .slot_mask  (slot_mask),
    .slot_pend  (slot_pend),
    .slot_req   (slot_req)
);

// File: tb/irq_route_bank_test.sv
module irq_route_bank_test;
    localparam int CLK_PERIOD = 10;
    localparam int NDEV       = 8;
    localparam int NVEC       = 17;

    // entry: [77] write, [76:65] addr, [64:33] wdata, [32] exp err, [31:0] exp rdata
    localparam logic [77:0] VECS [NVEC] = '{
        {1'b1, 12'h018, 32'hFFFF_FFFF, 1'b0, 32'h0000_0000},  // R2 write all ones dev3
        {1'b0, 12'h018, 32'h0,         1'b0, 32'h0000_1F3F},  // R2 only fields kept
        {1'b1, 12'h008, 32'h0000_0305, 1'b0, 32'h0000_0000},  // R2 dev1 cpu3 vec5
        {1'b0, 12'h008, 32'h0,         1'b0, 32'h0000_0305},  // R2
        {1'b0, 12'h000, 32'h0,         1'b0, 32'h0000_0000},  // R1 untouched route
        {1'b0, 12'h108, 32'h0,         1'b0, 32'h0000_0004},  // R1 masked after reset
        {1'b1, 12'h108, 32'h0,         1'b0, 32'h0000_0000},  // R4 unmask dev1
        {1'b0, 12'h108, 32'h0,         1'b0, 32'h0000_0000},  // R3
        {1'b1, 12'h138, 32'hFFFF_FFFF, 1'b0, 32'h0000_0000},  // R4 dev7 mask+clr
        {1'b0, 12'h138, 32'h0,         1'b0, 32'h0000_0004},  // R3 only bit2
        {1'b0, 12'h040, 32'h0,         1'b1, 32'h0000_0000},  // R8 index 8
        {1'b0, 12'h004, 32'h0,         1'b1, 32'h0000_0000},  // R8 misaligned
        {1'b1, 12'h200, 32'hFFFF_FFFF, 1'b1, 32'h0000_0000},  // R8 bank 2
        {1'b1, 12'h140, 32'h0,         1'b1, 32'h0000_0000},  // R8 ctrl index 8
        {1'b0, 12'h038, 32'h0,         1'b0, 32'h0000_0000},  // R2 dev7 route clean
        {1'b1, 12'h01C, 32'h0,         1'b1, 32'h0000_0000},  // R8 misaligned write
        {1'b0, 12'h018, 32'h0,         1'b0, 32'h0000_1F3F}   // R8 no effect seen
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic            req_write = 1'b0;
    logic [11:0]     req_addr = '0;
    logic [31:0]     req_wdata = '0;
    logic            rsp_valid;
    logic            rsp_err;
    logic [31:0]     rsp_rdata;
    logic [NDEV-1:0] dev_irq = '0;
    logic            post_valid;
    logic [4:0]      post_cpu;
    logic [5:0]      post_vec;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_route_bank #(.NUM_DEV(NDEV)) uut (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_err    (rsp_err),
        .rsp_rdata  (rsp_rdata),
        .dev_irq    (dev_irq),
        .post_valid (post_valid),
        .post_cpu   (post_cpu),
        .post_vec   (post_vec)
    );

    function automatic string tag_of(input int i);
        case (i)
            4, 5:                  return "R1";
            0, 1, 2, 3, 14:        return "R2";
            7, 9:                  return "R3";
            6, 8:                  return "R4";
            default:               return "R8";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // called at a falling edge; returns after the response edge
    task automatic access(input logic wr, input logic [11:0] a, input logic [31:0] d,
                          output logic e, output logic [31:0] q);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        chk("R9 rsp_valid", 32'(rsp_valid), 32'd1);
        e = rsp_err;
        q = rsp_rdata;
    endtask

    task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic e;
        logic [31:0] q;
        access(1'b0, a, 32'h0, e, q);
        chk(tag, 32'(e), 32'd0);
        chk(tag, q, exp);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        logic e;
        logic [31:0] q;
        access(1'b1, a, d, e, q);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL all: watchdog expired actual running expected done");
        finish_run();
    end

    initial begin
        logic e;
        logic [31:0] q;
        repeat (3) @(negedge clk);
        // R1: quiet outputs during reset
        chk("R1 post_valid in reset", 32'(post_valid), 32'd0);
        chk("R1 rsp_valid in reset", 32'(rsp_valid), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 post_valid after reset", 32'(post_valid), 32'd0);

        // register table
        for (int i = 0; i < NVEC; i++) begin
            access(VECS[i][77], VECS[i][76:65], VECS[i][64:33], e, q);
            chk($sformatf("%s err entry %0d", tag_of(i), i), 32'(e), 32'(VECS[i][32]));
            chk($sformatf("%s data entry %0d", tag_of(i), i), q, VECS[i][31:0]);
        end

        // R5: dev2 still masked, pulse ignored
        dev_irq[2] = 1'b1;
        @(negedge clk);
        dev_irq[2] = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk("R5 no post on masked slot", 32'(post_valid), 32'd0);
            @(negedge clk);
        end
        rd("R5 ctrl dev2 unchanged", 12'h110, 32'h4);

        // R6: dev1 unmasked, cpu3 vec5
        dev_irq[1] = 1'b1;
        @(negedge clk);
        dev_irq[1] = 1'b0;
        chk("R6 no post at capture edge", 32'(post_valid), 32'd0);
        @(negedge clk);
        chk("R6 post_valid", 32'(post_valid), 32'd1);
        chk("R6 post_cpu", 32'(post_cpu), 32'd3);
        chk("R6 post_vec", 32'(post_vec), 32'd5);
        @(negedge clk);
        chk("R6 post one cycle", 32'(post_valid), 32'd0);
        rd("R6 ctrl dev1 masked+pending", 12'h108, 32'h5);
        // second pulse while self-masked
        dev_irq[1] = 1'b1;
        @(negedge clk);
        dev_irq[1] = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk("R6 single delivery until unmask", 32'(post_valid), 32'd0);
            @(negedge clk);
        end
        // R4 and R3: unmask without clear keeps pending visible
        wr(12'h108, 32'h0);
        rd("R3 pending shown while unmasked", 12'h108, 32'h1);
        wr(12'h108, 32'h2);
        rd("R4 clear bit drops pending", 12'h108, 32'h0);

        // R7: dev3 and dev5 at once
        wr(12'h028, 32'h0000_0A11);
        wr(12'h118, 32'h0);
        wr(12'h128, 32'h0);
        dev_irq = 8'b0010_1000;
        @(negedge clk);
        dev_irq = '0;
        @(negedge clk);
        chk("R7 first post valid", 32'(post_valid), 32'd1);
        chk("R7 first post cpu", 32'(post_cpu), 32'h1F);
        chk("R7 first post vec", 32'(post_vec), 32'h3F);
        @(negedge clk);
        chk("R7 second post valid", 32'(post_valid), 32'd1);
        chk("R7 second post cpu", 32'(post_cpu), 32'h0A);
        chk("R7 second post vec", 32'(post_vec), 32'h11);
        @(negedge clk);
        chk("R7 queue drained", 32'(post_valid), 32'd0);

        // R10: capture and control write on dev6 in one cycle
        wr(12'h030, 32'h0000_0207);
        wr(12'h130, 32'h0);
        dev_irq[6] = 1'b1;
        req_valid  = 1'b1;
        req_write  = 1'b1;
        req_addr   = 12'h130;
        req_wdata  = 32'h2;
        @(negedge clk);
        dev_irq[6] = 1'b0;
        req_valid  = 1'b0;
        req_write  = 1'b0;
        chk("R10 response present", 32'(rsp_valid), 32'd1);
        @(negedge clk);
        chk("R10 post valid", 32'(post_valid), 32'd1);
        chk("R10 post cpu", 32'(post_cpu), 32'd2);
        chk("R10 post vec", 32'(post_vec), 32'd7);
        rd("R10 capture wins", 12'h130, 32'h5);

        finish_run();
    end
endmodule